// File: doc/BRIEF.md
# Write-Through Data Cache with Posted Write Buffer

This block sits between a processor load/store port and a slower external memory port. It keeps a direct-mapped copy of recently read memory lines (64 lines of 16 bytes by default, 1 KB in total). Loads that fall inside a programmable cacheable window and hit a valid line are answered from local storage. Loads that miss fetch the whole line from memory, one word at a time. Loads outside the window, or loads made while caching is switched off, go straight to memory and leave the cache untouched.

Every store is written through to memory. A store that hits a cached line also merges its enabled bytes into that line. A store that misses does not allocate. A one-entry write buffer can be switched on or off while the block runs. When it is on, a store is parked in the buffer and completes at once, and the buffer then writes memory on its own. When it is off, the store completes only after memory acknowledges the write. Loads that need memory wait until the buffer is empty, so a load never passes an earlier store.

The processor request channel and the memory request channel use valid/ready handshakes. A request is taken on a clock edge where valid and ready are both high. A sender that raises valid must hold it, and every request field, stable until that edge. The processor request ready depends on the request kind, because a store is refused while the buffer is occupied. Responses have no back-pressure: `cpu_rsp_valid` and `mem_rsp_valid` are one-cycle pulses that the receiver must take. The memory side has at most one request outstanding, and each request, read or write, gets exactly one `mem_rsp_valid`.

Top module: `wt_dcache`

## Requirements
- R1: After reset, `cpu_req_ready` is 1, and `cpu_rsp_valid` and `mem_req_valid` are 0.
- R2: A cacheable load that misses issues four memory reads to the word addresses of its 16-byte line, in order from offset 0 to offset 12, and returns the requested word. A later load that hits the line issues no memory request and raises `cpu_rsp_valid` on the clock edge that accepts it.
- R3: A non-cacheable load issues exactly one memory read of its word-aligned address, returns that data and allocates nothing. Repeating the load reads memory again.
- R4: Every store issues exactly one memory write carrying its address, data and byte enables, whether it hits or misses.
- R5: A store that hits merges the bytes enabled by `cpu_req_be` (bit n covers data bits 8n+7..8n) into the cached word. A store that misses leaves the cache unchanged, so a later load of that line misses.
- R6: With `wbuf_en` at 1, a store accepted while the buffer is empty raises `cpu_rsp_valid` on its accept edge, before memory has acknowledged the write.
- R7: With `wbuf_en` at 1 and the buffer occupied, `cpu_req_ready` stays 0 for a store until the buffered write has been acknowledged.
- R8: With `wbuf_en` at 0, `cpu_rsp_valid` for a store rises only on the edge after `mem_rsp_valid` for that write.
- R9: While the buffer holds a write, no memory read is issued. A load that follows a buffered store to the same address returns the stored data.
- R10: A one-cycle pulse on `invalidate_all`, or `cache_en` held at 0, makes every line invalid. A line whose fill is under way when the clear occurs stays invalid after the fill.
- R11: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the next cycle keeps `mem_req_valid` at 1 with address, write flag and data unchanged.
- R12: An access is cacheable when `cache_en` is 1 and (`cpu_req_addr` AND `region_mask`) equals `region_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_en | input | 1 | Caching on; at 0 all lines are invalid |
| wbuf_en | input | 1 | Posted write buffer on |
| invalidate_all | input | 1 | Pulse that invalidates every line |
| region_base | input | ADDR_W | Cacheable window base |
| region_mask | input | ADDR_W | Cacheable window compare mask |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Processor request taken |
| cpu_req_write | input | 1 | 1 for store, 0 for load |
| cpu_req_addr | input | ADDR_W | Byte address |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_req_be | input | DATA_W/8 | Store byte enables |
| cpu_rsp_valid | output | 1 | Access complete (one-cycle pulse) |
| cpu_rsp_rdata | output | DATA_W | Load data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request taken |
| mem_req_write | output | 1 | 1 for write |
| mem_req_addr | output | ADDR_W | Memory address |
| mem_req_wdata | output | DATA_W | Write data |
| mem_req_be | output | DATA_W/8 | Write byte enables |
| mem_rsp_valid | input | 1 | Read data or write acknowledge |
| mem_rsp_rdata | input | DATA_W | Read data |

## Verification
The bench loads a line by asking for its third word, which catches a fill that starts at the requested word or returns the wrong word. It follows a posted store straight away with a load and with a second store to the same region. A design that let the read go ahead of the buffered write would return stale memory data, and one that took a second store into a busy buffer would lose a write. A partial-byte store hit is read back, which exposes lanes merged the wrong way or a miss that wrongly allocates. A clear pulse is raised in the middle of a fill, which exposes a fill that marks its line valid from data fetched before the clear.

// File: rtl/wtc_pkg.sv
`timescale 1ns/1ps
package wtc_pkg;
  // Controller sequencing states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL_REQ,
    ST_FILL_WAIT,
    ST_UNC_REQ,
    ST_UNC_WAIT,
    ST_WR_REQ,
    ST_WR_WAIT
  } wtc_state_e;
endpackage

// File: rtl/wtc_tag_store.sv
`timescale 1ns/1ps
module wtc_tag_store #(
  parameter int NUM_LINES = 64,
  parameter int TAG_W     = 22,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_all,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [TAG_W-1:0] set_tag
);
  logic [NUM_LINES-1:0] valid_q;
  logic [TAG_W-1:0]     tag_q [NUM_LINES];

  // clear wins over a same-cycle set
  always_ff @(posedge clk) begin
    if (!rst_n)         valid_q <= '0;
    else if (clear_all) valid_q <= '0;
    else if (set_en)    valid_q[set_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (set_en) tag_q[set_idx] <= set_tag;
  end

  assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
endmodule

// File: rtl/wtc_data_store.sv
`timescale 1ns/1ps
module wtc_data_store #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [BE_W-1:0]   wr_be
);
  // one byte-wide array per lane so each lane has a single writer
  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    logic [7:0] lane_q [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && wr_be[b]) lane_q[wr_addr] <= wr_data[b*8 +: 8];
    end
    assign rd_data[b*8 +: 8] = lane_q[rd_addr];
  end
endmodule

// File: rtl/wtc_wbuf.sv
`timescale 1ns/1ps
module wtc_wbuf #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic [BE_W-1:0]   push_be,
  output logic              busy,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [ADDR_W-1:0] m_addr,
  output logic [DATA_W-1:0] m_data,
  output logic [BE_W-1:0]   m_be,
  input  logic              m_ack
);
  logic full_q, sent_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      sent_q <= 1'b0;
    end else if (push && !full_q) begin
      full_q <= 1'b1;
      sent_q <= 1'b0;
      m_addr <= push_addr;
      m_data <= push_data;
      m_be   <= push_be;
    end else if (full_q) begin
      if (!sent_q && m_ready) sent_q <= 1'b1;
      if (sent_q && m_ack) begin
        full_q <= 1'b0;
        sent_q <= 1'b0;
      end
    end
  end

  assign busy    = full_q;
  assign m_valid = full_q && !sent_q;
endmodule

// File: rtl/wt_dcache.sv
`timescale 1ns/1ps
module wt_dcache #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cache_en,
  input  logic                wbuf_en,
  input  logic                invalidate_all,
  input  logic [ADDR_W-1:0]   region_base,
  input  logic [ADDR_W-1:0]   region_mask,
  input  logic                cpu_req_valid,
  output logic                cpu_req_ready,
  input  logic                cpu_req_write,
  input  logic [ADDR_W-1:0]   cpu_req_addr,
  input  logic [DATA_W-1:0]   cpu_req_wdata,
  input  logic [DATA_W/8-1:0] cpu_req_be,
  output logic                cpu_rsp_valid,
  output logic [DATA_W-1:0]   cpu_rsp_rdata,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_req_write,
  output logic [ADDR_W-1:0]   mem_req_addr,
  output logic [DATA_W-1:0]   mem_req_wdata,
  output logic [DATA_W/8-1:0] mem_req_be,
  input  logic                mem_rsp_valid,
  input  logic [DATA_W-1:0]   mem_rsp_rdata
);
  import wtc_pkg::*;

  localparam int BE_W   = DATA_W / 8;
  localparam int OFF_W  = $clog2(BE_W);
  localparam int WORD_W = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - WORD_W - OFF_W;
  localparam int DEPTH  = NUM_LINES * LINE_WORDS;
  localparam int DA_W   = IDX_W + WORD_W;
  localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(LINE_WORDS - 1);

  wtc_state_e state_q;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_data;
  logic [BE_W-1:0]   lat_be;
  logic [WORD_W-1:0] cnt_q;
  logic [DATA_W-1:0] hold_q;
  logic              kill_q;

  // request fields
  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [WORD_W-1:0] req_word;
  logic [TAG_W-1:0]  lat_tag;
  logic [IDX_W-1:0]  lat_idx;
  logic [WORD_W-1:0] lat_word;

  assign req_tag  = cpu_req_addr[ADDR_W-1 -: TAG_W];
  assign req_idx  = cpu_req_addr[OFF_W+WORD_W +: IDX_W];
  assign req_word = cpu_req_addr[OFF_W +: WORD_W];
  assign lat_tag  = lat_addr[ADDR_W-1 -: TAG_W];
  assign lat_idx  = lat_addr[OFF_W+WORD_W +: IDX_W];
  assign lat_word = lat_addr[OFF_W +: WORD_W];

  logic cacheable, clear_all, lk_hit;
  assign cacheable = cache_en && ((cpu_req_addr & region_mask) == region_base);
  assign clear_all = invalidate_all || !cache_en;

  // write buffer
  logic              wb_push, wb_busy, wb_valid, wb_ack;
  logic [ADDR_W-1:0] wb_addr;
  logic [DATA_W-1:0] wb_data;
  logic [BE_W-1:0]   wb_be;

  assign cpu_req_ready = (state_q == ST_IDLE) && !(cpu_req_write && wbuf_en && wb_busy);

  logic accept;
  assign accept  = cpu_req_valid && cpu_req_ready;
  assign wb_push = accept && cpu_req_write && wbuf_en;

  // controller side of the memory port
  logic              ctl_valid, ctl_write, ctl_ack;
  logic [ADDR_W-1:0] ctl_addr;

  always_comb begin
    ctl_valid = 1'b0;
    ctl_write = 1'b0;
    ctl_addr  = lat_addr;
    unique case (state_q)
      ST_FILL_REQ: begin
        ctl_valid = !wb_busy;
        ctl_addr  = {lat_addr[ADDR_W-1:OFF_W+WORD_W], cnt_q, {OFF_W{1'b0}}};
      end
      ST_UNC_REQ: begin
        ctl_valid = !wb_busy;
        ctl_addr  = {lat_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      end
      ST_WR_REQ: begin
        ctl_valid = !wb_busy;
        ctl_write = 1'b1;
      end
      default: ;
    endcase
  end

  // the buffer owns the port whenever it holds an entry
  assign mem_req_valid = wb_busy ? wb_valid : ctl_valid;
  assign mem_req_write = wb_busy ? 1'b1     : ctl_write;
  assign mem_req_addr  = wb_busy ? wb_addr  : ctl_addr;
  assign mem_req_wdata = wb_busy ? wb_data  : lat_data;
  assign mem_req_be    = wb_busy ? wb_be    : lat_be;
  assign wb_ack        = mem_rsp_valid && wb_busy;
  assign ctl_ack       = mem_rsp_valid && !wb_busy;

  // storage write port: store hit or fill word
  logic              hit_wr, fill_wr, st_wr;
  logic [DA_W-1:0]   st_waddr;
  logic [DATA_W-1:0] st_wdata, rd_word;
  logic [BE_W-1:0]   st_be;
  logic              tag_set;

  assign hit_wr  = accept && cpu_req_write && cacheable && lk_hit;
  assign fill_wr = (state_q == ST_FILL_WAIT) && ctl_ack;
  assign st_wr   = hit_wr || fill_wr;

  always_comb begin
    if (fill_wr) begin
      st_waddr = {lat_idx, cnt_q};
      st_wdata = mem_rsp_rdata;
      st_be    = '1;
    end else begin
      st_waddr = {req_idx, req_word};
      st_wdata = cpu_req_wdata;
      st_be    = cpu_req_be;
    end
  end

  assign tag_set = fill_wr && (cnt_q == LAST_WORD) && !kill_q && !clear_all;

  wtc_tag_store #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_tag (
    .clk(clk), .rst_n(rst_n), .clear_all(clear_all),
    .lk_idx(req_idx), .lk_tag(req_tag), .lk_hit(lk_hit),
    .set_en(tag_set), .set_idx(lat_idx), .set_tag(lat_tag)
  );

  wtc_data_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rd_addr({req_idx, req_word}), .rd_data(rd_word),
    .wr_en(st_wr), .wr_addr(st_waddr), .wr_data(st_wdata), .wr_be(st_be)
  );

  wtc_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .push(wb_push),
    .push_addr(cpu_req_addr), .push_data(cpu_req_wdata), .push_be(cpu_req_be),
    .busy(wb_busy), .m_valid(wb_valid), .m_ready(mem_req_ready),
    .m_addr(wb_addr), .m_data(wb_data), .m_be(wb_be), .m_ack(wb_ack)
  );

  // sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_rdata <= '0;
      cnt_q         <= '0;
      kill_q        <= 1'b0;
    end else begin
      cpu_rsp_valid <= 1'b0;
      if (state_q != ST_IDLE) kill_q <= kill_q || clear_all;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            lat_addr <= cpu_req_addr;
            lat_data <= cpu_req_wdata;
            lat_be   <= cpu_req_be;
            kill_q   <= clear_all;
            cnt_q    <= '0;
            if (cpu_req_write) begin
              if (wbuf_en) begin
                cpu_rsp_valid <= 1'b1;
                cpu_rsp_rdata <= '0;
              end else begin
                state_q <= ST_WR_REQ;
              end
            end else if (cacheable && lk_hit) begin
              cpu_rsp_valid <= 1'b1;
              cpu_rsp_rdata <= rd_word;
            end else if (cacheable) begin
              state_q <= ST_FILL_REQ;
            end else begin
              state_q <= ST_UNC_REQ;
            end
          end
        end
        ST_FILL_REQ: if (ctl_valid && mem_req_ready) state_q <= ST_FILL_WAIT;
        ST_FILL_WAIT: begin
          if (ctl_ack) begin
            if (cnt_q == lat_word) hold_q <= mem_rsp_rdata;
            if (cnt_q == LAST_WORD) begin
              cpu_rsp_valid <= 1'b1;
              cpu_rsp_rdata <= (cnt_q == lat_word) ? mem_rsp_rdata : hold_q;
              state_q       <= ST_IDLE;
            end else begin
              cnt_q   <= cnt_q + 1'b1;
              state_q <= ST_FILL_REQ;
            end
          end
        end
        ST_UNC_REQ: if (ctl_valid && mem_req_ready) state_q <= ST_UNC_WAIT;
        ST_UNC_WAIT: begin
          if (ctl_ack) begin
            cpu_rsp_valid <= 1'b1;
            cpu_rsp_rdata <= mem_rsp_rdata;
            state_q       <= ST_IDLE;
          end
        end
        ST_WR_REQ: if (ctl_valid && mem_req_ready) state_q <= ST_WR_WAIT;
        ST_WR_WAIT: begin
          if (ctl_ack) begin
            cpu_rsp_valid <= 1'b1;
            cpu_rsp_rdata <= '0;
            state_q       <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wtc_checker.sv
`timescale 1ns/1ps
module wtc_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wbuf_en,
  input logic                 invalidate_all,
  input logic                 cpu_req_valid,
  input logic                 cpu_req_ready,
  input logic                 cpu_req_write,
  input logic                 cpu_rsp_valid,
  input logic                 mem_req_valid,
  input logic                 mem_req_ready,
  input logic                 mem_req_write,
  input logic [ADDR_W-1:0]    mem_req_addr,
  input logic [DATA_W-1:0]    mem_req_wdata,
  input logic                 mem_rsp_valid,
  input logic                 wb_busy,
  input logic                 cacheable,
  input logic                 lk_hit,
  input wtc_pkg::wtc_state_e  state_q
);
  AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata))); // R11

  AST_NO_READ_PAST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_busy |-> !(mem_req_valid && !mem_req_write)); // R9

  AST_BUSY_BUF_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wbuf_en && wb_busy && cpu_req_write) |-> !cpu_req_ready); // R7

  AST_HIT_SAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready && !cpu_req_write && cacheable && lk_hit) |=> cpu_rsp_valid); // R2

  AST_UNBUF_WAITS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == wtc_pkg::ST_WR_WAIT && !mem_rsp_valid) |=> !cpu_rsp_valid); // R8

  AST_CLEAR_ALL_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    invalidate_all |=> !lk_hit); // R10
endmodule

bind wt_dcache wtc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wbuf_en(wbuf_en), .invalidate_all(invalidate_all),
  .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
  .cpu_req_write(cpu_req_write), .cpu_rsp_valid(cpu_rsp_valid),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
  .wb_busy(wb_busy), .cacheable(cacheable), .lk_hit(lk_hit), .state_q(state_q)
);

// File: tb/sim_wt_dcache.sv
`timescale 1ns/1ps
module sim_wt_dcache;
  localparam int MLAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cache_en = 1'b1, wbuf_en = 1'b1, invalidate_all = 1'b0;
  logic [31:0] region_base = 32'h0000_1000, region_mask = 32'hFFFF_F000;
  logic        cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [31:0] cpu_req_addr = '0, cpu_req_wdata = '0;
  logic [3:0]  cpu_req_be = '0;
  logic        cpu_req_ready, cpu_rsp_valid;
  logic [31:0] cpu_rsp_rdata;
  logic        mem_req_valid, mem_req_ready, mem_req_write;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic [3:0]  mem_req_be;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;

  always #10 clk = ~clk;

  wt_dcache u0 (.*);

  // memory model
  logic [31:0] mem_arr [4096];
  logic        m_busy = 1'b0, m_wr = 1'b0, mem_stall = 1'b0;
  int          m_cnt = 0;
  logic [31:0] m_addr = '0, m_data = '0;
  logic [3:0]  m_be = '0;
  int          cyc = 0, rd_cnt = 0, wr_cnt = 0, wr_done = 0;
  logic [31:0] rd_log [16];
  logic [31:0] last_wr_addr = '0, last_wr_data = '0;
  logic [3:0]  last_wr_be = '0;

  function automatic logic [31:0] init_val(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, a[15:0]};
  endfunction

  assign mem_req_ready = !m_busy && !mem_stall;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      m_busy <= 1'b1; m_cnt <= MLAT; m_wr <= mem_req_write;
      m_addr <= mem_req_addr; m_data <= mem_req_wdata; m_be <= mem_req_be;
      if (mem_req_write) begin
        wr_cnt <= wr_cnt + 1; last_wr_addr <= mem_req_addr;
        last_wr_data <= mem_req_wdata; last_wr_be <= mem_req_be;
      end else begin
        rd_log[rd_cnt % 16] <= mem_req_addr; rd_cnt <= rd_cnt + 1;
      end
    end else if (m_busy) begin
      if (m_cnt > 1) m_cnt <= m_cnt - 1;
      else begin
        m_busy <= 1'b0; mem_rsp_valid <= 1'b1;
        if (m_wr) begin
          for (int b = 0; b < 4; b++)
            if (m_be[b]) mem_arr[m_addr[13:2]][b*8 +: 8] <= m_data[b*8 +: 8];
          wr_done <= wr_done + 1;
        end else mem_rsp_rdata <= mem_arr[m_addr[13:2]];
      end
    end
  end

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] d, input logic [3:0] be,
                        output logic [31:0] rd, output int lat, output int acc_wdone);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a;
    cpu_req_wdata = d; cpu_req_be = be;
    #1;
    while (!cpu_req_ready) begin @(negedge clk); #1; end
    acc_wdone = wr_done;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    lat = 0;
    while (!cpu_rsp_valid) begin @(negedge clk); lat++; end
    rd = cpu_rsp_rdata;
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic pulse_clear();
    @(negedge clk); invalidate_all = 1'b1;
    @(negedge clk); invalidate_all = 1'b0;
  endtask

  task automatic t_reset();
    chk(cpu_req_ready == 1'b1, "R1 ready", 32'(cpu_req_ready), 32'd1);
    chk(cpu_rsp_valid == 1'b0, "R1 rsp_valid", 32'(cpu_rsp_valid), 32'd0);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid", 32'(mem_req_valid), 32'd0);
  endtask

  task automatic t_fill_and_hit();
    logic [31:0] rd; int lat, wd, r0;
    r0 = rd_cnt;
    access(1'b0, 32'h1048, '0, '0, rd, lat, wd);
    chk(rd == init_val(32'h1048), "R2 miss data", rd, init_val(32'h1048));
    chk(rd_cnt == r0 + 4, "R2 fill read count", 32'(rd_cnt), 32'(r0 + 4));
    for (int i = 0; i < 4; i++)
      chk(rd_log[(r0 + i) % 16] == 32'h1040 + 32'(4 * i), "R2 fill order",
          rd_log[(r0 + i) % 16], 32'h1040 + 32'(4 * i));
    access(1'b0, 32'h104C, '0, '0, rd, lat, wd);
    chk(rd == init_val(32'h104C), "R2 hit data", rd, init_val(32'h104C));
    chk(lat == 0, "R2 hit latency", 32'(lat), 32'd0);
    chk(rd_cnt == r0 + 4, "R2 hit no memory read", 32'(rd_cnt), 32'(r0 + 4));
  endtask

  task automatic t_uncached();
    logic [31:0] rd; int lat, wd, r0;
    r0 = rd_cnt;
    access(1'b0, 32'h2013, '0, '0, rd, lat, wd);
    chk(rd == init_val(32'h2010), "R3 uncached data", rd, init_val(32'h2010));
    chk(rd_log[r0 % 16] == 32'h2010, "R3 uncached aligned addr", rd_log[r0 % 16], 32'h2010);
    access(1'b0, 32'h2010, '0, '0, rd, lat, wd);
    chk(rd_cnt == r0 + 2, "R12 outside window not allocated", 32'(rd_cnt), 32'(r0 + 2));
  endtask

  task automatic t_store_hit();
    logic [31:0] rd, exp; int lat, wd, w0, d0, r0;
    w0 = wr_cnt; d0 = wr_done; r0 = rd_cnt;
    access(1'b1, 32'h1044, 32'hDEADBEEF, 4'b0101, rd, lat, wd);
    chk(lat == 0, "R6 posted store latency", 32'(lat), 32'd0);
    chk(wr_done == d0, "R6 response before memory ack", 32'(wr_done), 32'(d0));
    settle();
    chk(wr_cnt == w0 + 1, "R4 one memory write", 32'(wr_cnt), 32'(w0 + 1));
    chk(last_wr_addr == 32'h1044 && last_wr_be == 4'b0101, "R4 write addr/be",
        last_wr_addr, 32'h1044);
    chk(last_wr_data == 32'hDEADBEEF, "R4 write data", last_wr_data, 32'hDEADBEEF);
    exp = (init_val(32'h1044) & 32'hFF00FF00) | (32'hDEADBEEF & 32'h00FF00FF);
    access(1'b0, 32'h1044, '0, '0, rd, lat, wd);
    chk(rd == exp, "R5 merged hit data", rd, exp);
    chk(rd_cnt == r0, "R5 hit stays cached", 32'(rd_cnt), 32'(r0));
  endtask

  task automatic t_store_miss();
    logic [31:0] rd; int lat, wd, w0, r0;
    w0 = wr_cnt; r0 = rd_cnt;
    access(1'b1, 32'h1100, 32'h11223344, 4'hF, rd, lat, wd);
    access(1'b0, 32'h1100, '0, '0, rd, lat, wd);
    chk(rd_cnt == r0 + 4, "R5 store miss no allocate", 32'(rd_cnt), 32'(r0 + 4));
    chk(rd == 32'h11223344, "R9 read sees buffered store", rd, 32'h11223344);
    chk(wr_cnt == w0 + 1, "R4 miss store written", 32'(wr_cnt), 32'(w0 + 1));
  endtask

  task automatic t_busy_buffer();
    logic [31:0] rd; int lat, wd, d0;
    settle();
    d0 = wr_done;
    access(1'b1, 32'h2000, 32'hA0A0A0A0, 4'hF, rd, lat, wd);
    access(1'b1, 32'h2004, 32'hB1B1B1B1, 4'hF, rd, lat, wd);
    chk(wd == d0 + 1, "R7 second store waits for drain", 32'(wd), 32'(d0 + 1));
    settle();
    chk(wr_done == d0 + 2, "R7 both stores written", 32'(wr_done), 32'(d0 + 2));
  endtask

  task automatic t_unbuffered();
    logic [31:0] rd; int lat, wd, d0;
    wbuf_en = 1'b0;
    d0 = wr_done;
    access(1'b1, 32'h2008, 32'hC2C2C2C2, 4'hF, rd, lat, wd);
    chk(wr_done == d0 + 1, "R8 store waits for memory ack", 32'(wr_done), 32'(d0 + 1));
    chk(lat > MLAT, "R8 store latency", 32'(lat), 32'(MLAT + 1));
    wbuf_en = 1'b1;
  endtask

  task automatic t_order_uncached();
    logic [31:0] rd; int lat, wd;
    access(1'b1, 32'h2020, 32'h5EED5EED, 4'hF, rd, lat, wd);
    access(1'b0, 32'h2020, '0, '0, rd, lat, wd);
    chk(rd == 32'h5EED5EED, "R9 uncached read after buffered store", rd, 32'h5EED5EED);
  endtask

  task automatic t_invalidate();
    logic [31:0] rd; int lat, wd, r0;
    access(1'b0, 32'h1040, '0, '0, rd, lat, wd);
    r0 = rd_cnt;
    pulse_clear();
    access(1'b0, 32'h1040, '0, '0, rd, lat, wd);
    chk(rd_cnt == r0 + 4, "R10 pulse clears lines", 32'(rd_cnt), 32'(r0 + 4));
    // clear during a fill
    fork
      access(1'b0, 32'h1300, '0, '0, rd, lat, wd);
      begin repeat (5) @(negedge clk); invalidate_all = 1'b1; @(negedge clk); invalidate_all = 1'b0; end
    join
    chk(rd == init_val(32'h1300), "R10 fill data still returned", rd, init_val(32'h1300));
    r0 = rd_cnt;
    access(1'b0, 32'h1304, '0, '0, rd, lat, wd);
    chk(rd_cnt == r0 + 4, "R10 killed fill stays invalid", 32'(rd_cnt), 32'(r0 + 4));
    // cache_en low clears and bypasses
    @(negedge clk); cache_en = 1'b0;
    r0 = rd_cnt;
    access(1'b0, 32'h1304, '0, '0, rd, lat, wd);
    chk(rd_cnt == r0 + 1, "R12 disabled cache goes to memory", 32'(rd_cnt), 32'(r0 + 1));
    @(negedge clk); cache_en = 1'b1;
    r0 = rd_cnt;
    access(1'b0, 32'h1304, '0, '0, rd, lat, wd);
    chk(rd_cnt == r0 + 4, "R10 disable cleared lines", 32'(rd_cnt), 32'(r0 + 4));
  endtask

  task automatic t_mem_stall();
    logic [31:0] rd, a0; int lat, wd;
    bit stable_ok = 1'b1;
    mem_stall = 1'b1;
    fork
      access(1'b0, 32'h2030, '0, '0, rd, lat, wd);
      begin
        repeat (3) @(negedge clk);
        a0 = mem_req_addr;
        for (int i = 0; i < 5; i++) begin
          if (!mem_req_valid || mem_req_addr != a0) stable_ok = 1'b0;
          @(negedge clk);
        end
        mem_stall = 1'b0;
      end
    join
    chk(stable_ok && a0 == 32'h2030, "R11 request held while stalled", a0, 32'h2030);
    chk(rd == init_val(32'h2030), "R11 stalled read data", rd, init_val(32'h2030));
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem_arr[i] = init_val(32'(i * 4));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_and_hit();
    t_uncached();
    t_store_hit();
    t_store_miss();
    t_busy_buffer();
    t_unbuffered();
    t_order_uncached();
    t_invalidate();
    t_mem_stall();
    settle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule